// File: doc/BRIEF.md
# Receive Descriptor Next-Address Sequencer

This block steps through a list of receive DMA descriptors held in memory. Each time a descriptor has been fetched, the fetch logic presents its control word, its status word and its two address words, and pulses `desc_done`. On that clock edge the sequencer latches the buffer addresses and byte counts for the data mover. It also computes the address of the descriptor to fetch next, and it follows frame boundaries so that it can raise a receive-complete interrupt.

There are three ways to reach the next descriptor. In the sequential case it sits right after the current one, plus a programmable gap. With the chain flag, the second address word points at it. With the end-of-ring flag, the walk returns to the list base, and this flag takes priority over the chain flag. Each descriptor can also suppress the completion interrupt on its own. Byte counts that do not fit the bus width are flagged, and so is a frame end that has no matching frame start.

Top module: `rxdesc_walker`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads `next_addr` with `base_addr` and clears `in_frame`, `rx_irq` and `seq_err`.
- R2: When a descriptor is accepted with control bits 15 and 14 both clear, `next_addr` becomes the old `next_addr` + 16 + `skip_words` × `BUS_BYTES`.
- R3: When control bit 15 (end of ring) is set, `next_addr` becomes `base_addr`. Bit 14 is then ignored, so the second address word stays a buffer pointer.
- R4: When control bit 14 (chain) is set and bit 15 is clear, `next_addr` becomes `desc_addr2`. In that case `buf2_valid` is 0, `buf2_size` is 0, and control bits 28:16 have no effect.
- R5: One cycle after acceptance, `buf1_addr` equals `desc_addr1` and `buf1_size` equals control bits 12:0. If the descriptor is not chained, `buf2_addr` equals `desc_addr2`, `buf2_size` equals control bits 28:16, and `buf2_valid` is 1. All outputs hold while `desc_done` is low.
- R6: `rx_irq` is a one-cycle pulse. It follows the acceptance of a descriptor that has status bit 8 (last) set and control bit 31 clear.
- R7: With control bit 31 set, a last descriptor raises no `rx_irq`.
- R8: Status bit 9 (first) without bit 8 sets `in_frame`. Status bit 8 clears it.
- R9: Status bit 8 without bit 9, accepted while `in_frame` is 0, gives a one-cycle `seq_err` pulse.
- R10: `size_err` is set for the last accepted descriptor when `buf1_size` is not a multiple of `BUS_BYTES`, or when an unchained second buffer size is not a multiple of `BUS_BYTES`. A second size inside a chained descriptor never sets it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| base_addr | input | AW | Base address of the descriptor list |
| skip_words | input | SKW | Gap between sequential descriptors, in bus words |
| desc_done | input | 1 | A fetched descriptor is present on the word inputs |
| desc_ctrl | input | 32 | Control word of the descriptor |
| desc_stat | input | 32 | Status word of the descriptor |
| desc_addr1 | input | AW | First buffer address |
| desc_addr2 | input | AW | Second buffer address or next descriptor pointer |
| next_addr | output | AW | Address of the next descriptor to fetch |
| buf1_addr | output | AW | First buffer address |
| buf1_size | output | 13 | First buffer byte count |
| buf2_addr | output | AW | Second buffer address |
| buf2_size | output | 13 | Second buffer byte count |
| buf2_valid | output | 1 | Second address word is a buffer |
| in_frame | output | 1 | A frame has started and not yet ended |
| rx_irq | output | 1 | Receive-complete interrupt pulse |
| seq_err | output | 1 | Pulse on a frame end that has no start |
| size_err | output | 1 | Byte count of the last descriptor is misaligned |

## Verification
The hardest state to reach is a descriptor that sets both the end-of-ring and chain flags and also carries a misaligned second size. Reaching it needs a walk that has already left the base address through chaining and sequential steps, so the wrap back to base can be seen. A second hard case is a frame end that arrives outside any frame, which can only happen once an earlier frame has closed. The vector table orders its descriptors so that a chained hop, a suppressed frame end, a combined wrap, an orphan frame end and a misaligned unchained buffer follow one another. A directed reset in the middle of a frame then moves the base and checks that the walk restarts there.

// File: rtl/rxdesc_walker.sv
module rxdesc_walker #(
  parameter int AW        = 32,
  parameter int BUS_BYTES = 4,
  parameter int SKW       = 5
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [AW-1:0]  base_addr,
  input  logic [SKW-1:0] skip_words,
  input  logic           desc_done,
  input  logic [31:0]    desc_ctrl,
  input  logic [31:0]    desc_stat,
  input  logic [AW-1:0]  desc_addr1,
  input  logic [AW-1:0]  desc_addr2,
  output logic [AW-1:0]  next_addr,
  output logic [AW-1:0]  buf1_addr,
  output logic [12:0]    buf1_size,
  output logic [AW-1:0]  buf2_addr,
  output logic [12:0]    buf2_size,
  output logic           buf2_valid,
  output logic           in_frame,
  output logic           rx_irq,
  output logic           seq_err,
  output logic           size_err
);

  localparam int ALB        = $clog2(BUS_BYTES);
  localparam int DESC_BYTES = 16;

  logic          wrap, chained, no_irq, f_first, f_last;
  logic [12:0]   sz1, sz2;
  logic          bad1, bad2;
  logic [AW-1:0] step, upcoming;
  logic          unused_bits;

  assign wrap    = desc_ctrl[15];
  assign chained = desc_ctrl[14] & ~wrap;
  assign no_irq  = desc_ctrl[31];
  assign f_first = desc_stat[9];
  assign f_last  = desc_stat[8];
  assign sz1     = desc_ctrl[12:0];
  assign sz2     = desc_ctrl[28:16];
  assign bad1    = |sz1[ALB-1:0];
  assign bad2    = ~chained & (|sz2[ALB-1:0]);
  assign step    = AW'(DESC_BYTES) + (AW'(skip_words) << ALB);

  assign upcoming = wrap    ? base_addr  :
                    chained ? desc_addr2 :
                              next_addr + step;

  assign unused_bits = ^{desc_ctrl[30:29], desc_ctrl[13],
                         desc_stat[31:10], desc_stat[7:0]};

  always_ff @(posedge clk) begin
    if (rst) begin
      next_addr  <= base_addr;
      buf1_addr  <= '0;
      buf1_size  <= '0;
      buf2_addr  <= '0;
      buf2_size  <= '0;
      buf2_valid <= 1'b0;
      in_frame   <= 1'b0;
      rx_irq     <= 1'b0;
      seq_err    <= 1'b0;
      size_err   <= 1'b0;
    end else begin
      rx_irq  <= 1'b0;
      seq_err <= 1'b0;
      if (desc_done) begin
        next_addr  <= upcoming;
        buf1_addr  <= desc_addr1;
        buf1_size  <= sz1;
        buf2_addr  <= chained ? '0 : desc_addr2;
        buf2_size  <= chained ? '0 : sz2;
        buf2_valid <= ~chained;
        size_err   <= bad1 | bad2;
        rx_irq     <= f_last & ~no_irq;
        seq_err    <= f_last & ~f_first & ~in_frame;
        if (f_last)
          in_frame <= 1'b0;
        else if (f_first)
          in_frame <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxdesc_walker_chk.sv
module rxdesc_walker_chk #(
  parameter int AW        = 32,
  parameter int BUS_BYTES = 4,
  parameter int SKW       = 5
) (
  input logic           clk,
  input logic           rst,
  input logic [AW-1:0]  base_addr,
  input logic [SKW-1:0] skip_words,
  input logic           desc_done,
  input logic [31:0]    desc_ctrl,
  input logic [31:0]    desc_stat,
  input logic [AW-1:0]  desc_addr1,
  input logic [AW-1:0]  desc_addr2,
  input logic [AW-1:0]  next_addr,
  input logic [AW-1:0]  buf1_addr,
  input logic [12:0]    buf1_size,
  input logic [AW-1:0]  buf2_addr,
  input logic [12:0]    buf2_size,
  input logic           buf2_valid,
  input logic           in_frame,
  input logic           rx_irq,
  input logic           seq_err,
  input logic           size_err
);
  localparam int ALB = $clog2(BUS_BYTES);

  assert_reset_base_R1: assert property (@(posedge clk)
    rst |=> (next_addr == $past(base_addr)) && !in_frame && !rx_irq && !seq_err);

  assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
    desc_done && !desc_ctrl[15] && !desc_ctrl[14] |=>
      next_addr == $past(next_addr) + AW'(16) + (AW'($past(skip_words)) << ALB));

  assert_ring_wrap_R3: assert property (@(posedge clk) disable iff (rst)
    desc_done && desc_ctrl[15] |=> (next_addr == $past(base_addr)) && buf2_valid);

  assert_chain_hop_R4: assert property (@(posedge clk) disable iff (rst)
    desc_done && desc_ctrl[14] && !desc_ctrl[15] |=>
      (next_addr == $past(desc_addr2)) && !buf2_valid && (buf2_size == 13'd0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !desc_done |=> $stable(next_addr) && $stable(buf1_addr) && $stable(buf2_size));

  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    rx_irq |-> $past(desc_done) && $past(desc_stat[8]) && !$past(desc_ctrl[31]));

  assert_irq_mask_R7: assert property (@(posedge clk) disable iff (rst)
    desc_done && desc_ctrl[31] |=> !rx_irq);

  assert_frame_open_R8: assert property (@(posedge clk) disable iff (rst)
    desc_done && desc_stat[9] && !desc_stat[8] |=> in_frame);

  assert_orphan_end_R9: assert property (@(posedge clk) disable iff (rst)
    desc_done && desc_stat[8] && !desc_stat[9] && !in_frame |=> seq_err);

  assert_buf1_align_R10: assert property (@(posedge clk) disable iff (rst)
    desc_done && (desc_ctrl[ALB-1:0] != '0) |=> size_err);
endmodule

bind rxdesc_walker rxdesc_walker_chk #(.AW(AW), .BUS_BYTES(BUS_BYTES), .SKW(SKW)) u_chk (.*);

// File: tb/rxdesc_walker_bench.sv
module rxdesc_walker_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] base_addr = 32'h1000;
  logic [4:0]  skip_words = '0;
  logic        desc_done = 1'b0;
  logic [31:0] desc_ctrl = '0, desc_stat = '0, desc_addr1 = '0, desc_addr2 = '0;
  logic [31:0] next_addr, buf1_addr, buf2_addr;
  logic [12:0] buf1_size, buf2_size;
  logic        buf2_valid, in_frame, rx_irq, seq_err, size_err;

  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #2 clk = ~clk;

  rxdesc_walker u_rxdesc_walker (.*);

  typedef struct packed {
    logic [31:0] ctrl, stat, a1, a2;
    logic [4:0]  skip;
    logic [31:0] nxt;
    logic [12:0] b2sz;
    logic        b2v, irq, seq, serr, inf;
  } vec_t;

  localparam vec_t VEC [8] = '{
    '{32'h0080_0040, 32'h300, 32'hA000, 32'hB000, 5'd0, 32'h1010, 13'h80, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h0080_0040, 32'h200, 32'hA100, 32'hB100, 5'd2, 32'h1028, 13'h80, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h0007_4020, 32'h000, 32'hA200, 32'h2000, 5'd0, 32'h2000, 13'h0,  1'b0, 1'b0, 1'b0, 1'b0, 1'b1},
    '{32'h8000_0010, 32'h100, 32'hA300, 32'hB300, 5'd0, 32'h2010, 13'h0,  1'b1, 1'b0, 1'b0, 1'b0, 1'b0},
    '{32'h0010_C030, 32'h300, 32'hA400, 32'h3000, 5'd0, 32'h1000, 13'h10, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0},
    '{32'h0000_0022, 32'h100, 32'hA500, 32'hB500, 5'd0, 32'h1010, 13'h0,  1'b1, 1'b1, 1'b1, 1'b1, 1'b0},
    '{32'h0006_0040, 32'h200, 32'hA600, 32'hB600, 5'd0, 32'h1020, 13'h6,  1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
    '{32'h0000_0040, 32'h100, 32'hA700, 32'hB700, 5'd0, 32'h1030, 13'h0,  1'b1, 1'b1, 1'b0, 1'b0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic feed(input vec_t v);
    @(negedge clk);
    desc_ctrl = v.ctrl; desc_stat = v.stat; desc_addr1 = v.a1; desc_addr2 = v.a2;
    skip_words = v.skip; desc_done = 1'b1;
    @(negedge clk);
    desc_done = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk(next_addr == 32'h1000, "R1 reset next_addr", next_addr, 32'h1000);
    chk(!in_frame && !rx_irq && !seq_err, "R1 reset flags", {in_frame, rx_irq, seq_err}, 0);

    for (int i = 0; i < 8; i++) begin
      feed(VEC[i]);
      chk(next_addr == VEC[i].nxt, $sformatf("R2/R3/R4 next_addr v%0d", i), next_addr, VEC[i].nxt);
      chk(buf1_addr == VEC[i].a1 && buf1_size == VEC[i].ctrl[12:0],
          $sformatf("R5 buf1 v%0d", i), buf1_addr, VEC[i].a1);
      chk(buf2_size == VEC[i].b2sz && buf2_valid == VEC[i].b2v,
          $sformatf("R4/R5 buf2 v%0d", i), {buf2_valid, buf2_size}, {VEC[i].b2v, VEC[i].b2sz});
      if (VEC[i].b2v)
        chk(buf2_addr == VEC[i].a2, $sformatf("R5 buf2_addr v%0d", i), buf2_addr, VEC[i].a2);
      chk(rx_irq == VEC[i].irq, $sformatf("R6/R7 rx_irq v%0d", i), rx_irq, VEC[i].irq);
      chk(seq_err == VEC[i].seq, $sformatf("R9 seq_err v%0d", i), seq_err, VEC[i].seq);
      chk(size_err == VEC[i].serr, $sformatf("R10 size_err v%0d", i), size_err, VEC[i].serr);
      chk(in_frame == VEC[i].inf, $sformatf("R8 in_frame v%0d", i), in_frame, VEC[i].inf);
      @(negedge clk);
      chk(!rx_irq && !seq_err, $sformatf("R6 single pulse v%0d", i), {rx_irq, seq_err}, 0);
      chk(next_addr == VEC[i].nxt, $sformatf("R5 hold v%0d", i), next_addr, VEC[i].nxt);
    end

    feed('{32'h0000_0040, 32'h200, 32'hC000, 32'hC100, 5'd0, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    chk(in_frame, "R8 frame open before reset", in_frame, 1);
    @(negedge clk);
    base_addr = 32'h4000;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(next_addr == 32'h4000, "R1 mid-run reset base", next_addr, 32'h4000);
    chk(!in_frame, "R1 mid-run reset frame", in_frame, 0);

    feed('{32'h0000_0040, 32'h100, 32'hC200, 32'hC300, 5'd1, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    chk(next_addr == 32'h4014, "R2 step with skip after reset", next_addr, 32'h4014);
    chk(seq_err, "R9 orphan end after reset", seq_err, 1);
    chk(rx_irq, "R6 irq on orphan end", rx_irq, 1);

    feed('{32'h8001_4043, 32'h300, 32'hC400, 32'h5000, 5'd0, 32'h0, 13'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0});
    chk(next_addr == 32'h5000, "R4 chain hop", next_addr, 32'h5000);
    chk(!rx_irq, "R7 suppressed", rx_irq, 0);
    chk(size_err, "R10 buf1 misaligned in chained", size_err, 1);

    done_flag = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule